// File: doc/BRIEF.md
# PLL Reset and Reference-Select Sequencer

This core-side controller switches a hard PLL between its four reference clocks without disturbing it. A request carries a new source index. The sequencer first pulls the PLL's active-low reset down. It moves the select bus only after that, holds reset for a minimum number of controller cycles, and waits for the core to report that the chosen reference is stable. Only then does it release reset.

After release, the sequencer watches the PLL's lock output. That output is asynchronous and can glitch, so it passes through a two-flop synchronizer. Lock is trusted only after it has stayed high for a set number of consecutive cycles. A qualified lock ends the sequence with a done pulse and raises the locked indication. If lock never arrives within a timeout, the sequencer flags an error and goes idle with reset left released. If a trusted lock later drops, a sticky lost flag is set and stays set until it is cleared. The same sequence runs once after power-up, using a default source index.

Top module: `pll_refsel_seq`

## Requirements
- R1: While `rst_n` is low, `pll_rstn` is 0, `pll_sel` equals `INIT_SEL` (0 by default), `busy` is 1, and `locked`, `done`, `lock_lost` and `lock_err` are all 0. On leaving reset, the power-up sequence runs toward `INIT_SEL`.
- R2: `pll_sel` changes only when `pll_rstn` was 0 in the previous cycle and is 0 in the current one. Once a sequence ends, `pll_sel` equals the index of the accepted request.
- R3: Each low period of `pll_rstn` lasts at least `RST_CYC` cycles. `RST_CYC` is the ceiling of `MIN_RST_PS / CLK_PERIOD_PS`, and is never less than 1.
- R4: `pll_rstn` rises only after `ref_stable` has been seen high. While `ref_stable` stays low, reset stays asserted, and this includes the power-up sequence.
- R5: `locked` is raised only after the synchronized lock input has been high for `LOCK_FILT` consecutive cycles. Shorter high pulses never produce `locked`.
- R6: `busy` is 1 from the cycle after a request is accepted until the sequence ends. A sequence that ends in lock sets `locked`, clears `busy`, and gives exactly one one-cycle `done` pulse.
- R7: A request (`req_valid` high) made while `busy` is 1 is ignored. The sequence in progress completes with the index it was started with.
- R8: If qualified lock drops while `locked` is 1, then `locked` falls, `busy` stays 0, and `lock_lost` becomes 1. `lock_lost` stays at 1 until a cycle with `lost_clr` high clears it.
- R9: If qualified lock has not arrived `LOCK_TIMEOUT` cycles after `pll_rstn` rises, `lock_err` is set and the sequence ends. At that point `busy` is 0, `locked` is 0, `pll_rstn` stays 1, and one `done` pulse is given.
- R10: A request is accepted while idle or while locked, and accepting it clears `lock_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset of the controller |
| req_valid | input | 1 | One-cycle request to switch reference |
| req_sel | input | SEL_W | Reference index requested |
| ref_stable | input | 1 | Core indication that the chosen reference is stable (synchronous to clk) |
| pll_lock_async | input | 1 | Raw lock output of the PLL, asynchronous |
| lost_clr | input | 1 | Clears the sticky lock-lost flag |
| pll_rstn | output | 1 | Active-low reset to the PLL |
| pll_sel | output | SEL_W | Reference select bus to the PLL |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| locked | output | 1 | Qualified lock held since the last sequence |
| lock_lost | output | 1 | Sticky: a trusted lock was lost |
| lock_err | output | 1 | The last sequence timed out waiting for lock |

## Verification
The bench uses a behavioural PLL whose lock comes some number of cycles after reset release. The power-up test holds the reference unstable to show that reset is not released early. Lock glitches one cycle shorter than the filter length are injected. A design that skipped the filter, or filtered one cycle too short, would raise `locked` on these glitches. A second request is made while a sequence is running. A design that did not guard this would end on the wrong reference, or would move the select bus mid-sequence while reset was high. The bench also forces a lock timeout, drops lock after it has been trusted, and clears the sticky flag. A design that got these wrong would leave `busy` stuck, would lose the lost flag too early, or would carry a stale error into the next successful switch.

// File: rtl/refsel_pkg.sv
// Package refsel_pkg
// Holds the shared state encoding of the reference-select sequencer.
// Assumes nothing beyond a 3-bit encoding being wide enough.
package refsel_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ASSERT_RST,
        S_CHANGE_SEL,
        S_HOLD_RST,
        S_WAIT_STABLE,
        S_RELEASE,
        S_WAIT_LOCK,
        S_LOCKED
    } seq_state_t;

endpackage

// File: rtl/lock_qual.sv
// Module lock_qual
// Brings the asynchronous PLL lock into the clk domain through two flops.
// It reports lock_ok only after the synchronized level has stayed high for
// FILT consecutive cycles. Any low sample drops lock_ok at once.
// Assumes FILT >= 1.
module lock_qual #(
    parameter int FILT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_async,
    output logic lock_ok
);

    localparam int FW = $clog2(FILT + 1);

    logic [1:0]    sync_q;
    logic [FW-1:0] run_q;

    // Two-stage synchronizer for the raw lock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], lock_async};
    end

    // Count consecutive high samples; qualify once the run reaches FILT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            lock_ok <= 1'b0;
        end else if (!sync_q[1]) begin
            run_q   <= '0;
            lock_ok <= 1'b0;
        end else if (run_q == FW'(FILT - 1)) begin
            lock_ok <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/cyc_counter.sv
// Module cyc_counter
// A saturating up-counter with a synchronous clear. The sequencer uses it
// for both the reset hold time and the lock timeout.
// Assumes clear and enable are never needed in the same cycle (clear wins).
module cyc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);

    // Clear, advance or hold the count; stop at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                 count <= '0;
        else if (clr)               count <= '0;
        else if (en && count != '1) count <= count + 1'b1;
    end

endmodule

// File: rtl/seq_fsm.sv
// Module seq_fsm
// Controls the PLL reset and the reference select through the sequence
// assert-reset, move-select, hold, wait-stable, release, wait-lock.
// The select register is written only in S_CHANGE_SEL, which is entered
// one cycle after pll_rstn has gone low. Power-up starts in S_ASSERT_RST.
// Assumes cnt comes from an external counter driven by cnt_clr/cnt_en.
module seq_fsm
    import refsel_pkg::*;
#(
    parameter int SEL_W        = 2,
    parameter int INIT_SEL     = 0,
    parameter int RST_CYC      = 1,
    parameter int LOCK_TIMEOUT = 4096,
    parameter int CNT_W        = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SEL_W-1:0] req_sel,
    input  logic             ref_stable,
    input  logic             lock_ok,
    input  logic             lost_clr,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             cnt_en,
    output logic             pll_rstn,
    output logic [SEL_W-1:0] pll_sel,
    output logic             busy,
    output logic             done,
    output logic             locked,
    output logic             lock_lost,
    output logic             lock_err
);

    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] TOUT_LAST = CNT_W'(LOCK_TIMEOUT - 1);
    localparam logic [SEL_W-1:0] SEL_RST   = SEL_W'(INIT_SEL);

    seq_state_t       state_q;
    logic [SEL_W-1:0] target_q;
    logic             accept;

    // Requests are taken only when no sequence is running.
    assign accept = req_valid && (state_q == S_IDLE || state_q == S_LOCKED);

    // Counter control: clear on entry to each timed wait, count inside it.
    always_comb begin
        cnt_clr = (state_q == S_CHANGE_SEL) || (state_q == S_RELEASE);
        cnt_en  = (state_q == S_HOLD_RST)   || (state_q == S_WAIT_LOCK);
    end

    // Status decoded from the state.
    always_comb begin
        busy   = !(state_q == S_IDLE || state_q == S_LOCKED);
        locked = (state_q == S_LOCKED);
    end

    // Sequencing, PLL pin registers and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_ASSERT_RST;
            target_q  <= SEL_RST;
            pll_sel   <= SEL_RST;
            pll_rstn  <= 1'b0;
            done      <= 1'b0;
            lock_lost <= 1'b0;
            lock_err  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (lost_clr) lock_lost <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        target_q <= req_sel;
                        lock_err <= 1'b0;
                        state_q  <= S_ASSERT_RST;
                    end
                end
                S_ASSERT_RST: begin
                    pll_rstn <= 1'b0;
                    state_q  <= S_CHANGE_SEL;
                end
                S_CHANGE_SEL: begin
                    pll_sel <= target_q;
                    state_q <= S_HOLD_RST;
                end
                S_HOLD_RST: begin
                    if (cnt >= HOLD_LAST) state_q <= S_WAIT_STABLE;
                end
                S_WAIT_STABLE: begin
                    if (ref_stable) state_q <= S_RELEASE;
                end
                S_RELEASE: begin
                    pll_rstn <= 1'b1;
                    state_q  <= S_WAIT_LOCK;
                end
                S_WAIT_LOCK: begin
                    if (lock_ok) begin
                        done    <= 1'b1;
                        state_q <= S_LOCKED;
                    end else if (cnt >= TOUT_LAST) begin
                        done     <= 1'b1;
                        lock_err <= 1'b1;
                        state_q  <= S_IDLE;
                    end
                end
                S_LOCKED: begin
                    if (accept) begin
                        target_q <= req_sel;
                        lock_err <= 1'b0;
                        state_q  <= S_ASSERT_RST;
                    end else if (!lock_ok) begin
                        lock_lost <= 1'b1;
                        state_q   <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pll_refsel_seq.sv
// Module pll_refsel_seq
// Top of the PLL reset and reference-select sequencer. It ties together the
// lock qualifier, the shared cycle counter and the sequencing FSM.
// Assumes ref_stable is already synchronous to clk. pll_lock_async may be
// fully asynchronous.
module pll_refsel_seq #(
    parameter int SEL_W         = 2,
    parameter int INIT_SEL      = 0,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int MIN_RST_PS    = 10000,
    parameter int LOCK_FILT     = 8,
    parameter int LOCK_TIMEOUT  = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SEL_W-1:0] req_sel,
    input  logic             ref_stable,
    input  logic             pll_lock_async,
    input  logic             lost_clr,
    output logic             pll_rstn,
    output logic [SEL_W-1:0] pll_sel,
    output logic             busy,
    output logic             done,
    output logic             locked,
    output logic             lock_lost,
    output logic             lock_err
);

    localparam int RST_RAW = (MIN_RST_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int RST_CYC = (RST_RAW < 1) ? 1 : RST_RAW;
    localparam int CNT_MAX = (RST_CYC > LOCK_TIMEOUT) ? RST_CYC : LOCK_TIMEOUT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             lock_ok;
    logic             cnt_clr;
    logic             cnt_en;
    logic [CNT_W-1:0] cnt;

    lock_qual #(.FILT(LOCK_FILT)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_async (pll_lock_async),
        .lock_ok    (lock_ok)
    );

    cyc_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .count (cnt)
    );

    seq_fsm #(
        .SEL_W        (SEL_W),
        .INIT_SEL     (INIT_SEL),
        .RST_CYC      (RST_CYC),
        .LOCK_TIMEOUT (LOCK_TIMEOUT),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_sel    (req_sel),
        .ref_stable (ref_stable),
        .lock_ok    (lock_ok),
        .lost_clr   (lost_clr),
        .cnt        (cnt),
        .cnt_clr    (cnt_clr),
        .cnt_en     (cnt_en),
        .pll_rstn   (pll_rstn),
        .pll_sel    (pll_sel),
        .busy       (busy),
        .done       (done),
        .locked     (locked),
        .lock_lost  (lock_lost),
        .lock_err   (lock_err)
    );

endmodule

// File: rtl/refsel_chk.sv
// Module refsel_chk
// Protocol checker for pll_refsel_seq, attached by bind. It observes only
// the top-level ports. Low periods of pll_rstn are measured with a local
// counter rather than with deep $past.
module refsel_chk #(
    parameter int SEL_W   = 2,
    parameter int RST_CYC = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_stable,
    input logic             lost_clr,
    input logic             pll_rstn,
    input logic [SEL_W-1:0] pll_sel,
    input logic             busy,
    input logic             locked,
    input logic             lock_lost,
    input logic             lock_err
);

    logic [15:0] low_run;

    // Length of the current low period of pll_rstn, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                          low_run <= '0;
        else if (pll_rstn)                   low_run <= '0;
        else if (low_run != 16'hFFFF)        low_run <= low_run + 1'b1;
    end

    p_sel_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_sel != $past(pll_sel)) |-> (!pll_rstn && !$past(pll_rstn)));

    p_min_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_rstn) |-> ($past(low_run) >= 16'(RST_CYC)));

    p_release_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_rstn) |-> $past(ref_stable, 2));

    p_locked_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (!busy && pll_rstn));

    p_lost_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lost && !lost_clr) |=> lock_lost);

    p_err_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_err) |-> (pll_rstn && !busy && !locked));

endmodule

bind pll_refsel_seq refsel_chk #(.SEL_W(SEL_W), .RST_CYC(RST_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_stable (ref_stable),
    .lost_clr   (lost_clr),
    .pll_rstn   (pll_rstn),
    .pll_sel    (pll_sel),
    .busy       (busy),
    .locked     (locked),
    .lock_lost  (lock_lost),
    .lock_err   (lock_err)
);

// File: tb/tb_pll_refsel_seq.sv
module tb_pll_refsel_seq;

    localparam int RST_CYC  = 5;
    localparam int FILT     = 4;
    localparam int TIMEOUT  = 200;
    localparam int NVEC     = 5;
    localparam int V_SEL [NVEC] = '{1, 3, 2, 0, 3};
    localparam int V_DLY [NVEC] = '{10, 40, 300, 5, 1};
    localparam int V_OK  [NVEC] = '{1, 1, 0, 1, 1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_sel = 2'd0;
    logic       ref_stable = 1'b0;
    logic       lost_clr = 1'b0;
    logic       kill = 1'b0;
    logic       glitch = 1'b0;
    logic       model_lock;
    logic       lock_in;
    logic       pll_rstn, busy, done, locked, lock_lost, lock_err;
    logic [1:0] pll_sel;

    int checks = 0;
    int errors = 0;
    int model_delay = 10;
    int mcnt;
    int done_cnt;
    int low_run;
    int last_low;
    int sel_viol = 0;
    logic [1:0] prev_sel = 2'd0;
    logic       prev_rstn = 1'b0;
    logic       finished = 1'b0;

    always #5 clk = ~clk;

    assign lock_in = (model_lock && !kill) || glitch;

    pll_refsel_seq #(
        .SEL_W(2), .INIT_SEL(0), .CLK_PERIOD_PS(10000), .MIN_RST_PS(45000),
        .LOCK_FILT(FILT), .LOCK_TIMEOUT(TIMEOUT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .ref_stable(ref_stable), .pll_lock_async(lock_in), .lost_clr(lost_clr),
        .pll_rstn(pll_rstn), .pll_sel(pll_sel), .busy(busy), .done(done),
        .locked(locked), .lock_lost(lock_lost), .lock_err(lock_err)
    );

    // Behavioural PLL: lock comes model_delay cycles after reset release.
    always_ff @(posedge clk) begin
        if (!pll_rstn) begin
            mcnt <= 0;
            model_lock <= 1'b0;
        end else if (mcnt >= model_delay) begin
            model_lock <= 1'b1;
        end else begin
            mcnt <= mcnt + 1;
        end
    end

    // Done pulses and reset low-period lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_cnt <= 0;
            low_run  <= 0;
            last_low <= 0;
        end else begin
            if (done) done_cnt <= done_cnt + 1;
            if (!pll_rstn) low_run <= low_run + 1;
            else if (low_run != 0) begin
                last_low <= low_run;
                low_run  <= 0;
            end
        end
    end

    // Select bus may move only while reset is held across both samples.
    always @(negedge clk) begin
        if (rst_n && pll_sel != prev_sel && (pll_rstn || prev_rstn))
            sel_viol = sel_viol + 1;
        prev_sel  = pll_sel;
        prev_rstn = pll_rstn;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        @(negedge clk);
    endtask

    task automatic request(input int sel);
        @(negedge clk);
        req_valid = 1'b1;
        req_sel   = 2'(sel);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int d0;
        // R1: reset values
        repeat (5) @(negedge clk);
        chk("R1 pll_rstn", int'(pll_rstn), 0);
        chk("R1 pll_sel", int'(pll_sel), 0);
        chk("R1 busy", int'(busy), 1);
        chk("R1 locked", int'(locked), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 flags", int'(lock_lost) + int'(lock_err), 0);
        rst_n = 1'b1;

        // R4: power-up must not release reset before the reference is stable
        repeat (30) @(negedge clk);
        chk("R4 held", int'(pll_rstn), 0);
        chk("R4 busy", int'(busy), 1);
        ref_stable = 1'b1;
        wait_idle();
        chk("R6 powerup locked", int'(locked), 1);
        chk("R1 powerup sel", int'(pll_sel), 0);
        chk("R3 powerup low", int'(last_low >= RST_CYC), 1);

        // Table of requests: select, PLL lock delay, expected success
        for (int i = 0; i < NVEC; i++) begin
            model_delay = V_DLY[i];
            d0 = done_cnt;
            request(V_SEL[i]);
            chk("R6 busy", int'(busy), 1);
            wait_idle();
            chk("R2 sel", int'(pll_sel), V_SEL[i]);
            chk("R6 locked", int'(locked), V_OK[i]);
            chk("R10 err", int'(lock_err), 1 - V_OK[i]);
            chk("R6 done", done_cnt - d0, 1);
            chk("R3 low", int'(last_low >= RST_CYC), 1);
            chk("R9 rstn", int'(pll_rstn), 1);
        end

        // R7: second request while busy is ignored
        model_delay = 10;
        d0 = done_cnt;
        request(1);
        req_valid = 1'b1;
        req_sel   = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        chk("R7 sel", int'(pll_sel), 1);
        chk("R7 done", done_cnt - d0, 1);
        chk("R7 locked", int'(locked), 1);

        // R5 and R9: short lock glitches, then timeout
        model_delay = 100000;
        request(2);
        for (int i = 0; i < 50; i++) begin
            if (pll_rstn) break;
            @(negedge clk);
        end
        for (int g = 0; g < 3; g++) begin
            glitch = 1'b1;
            repeat (FILT - 1) @(negedge clk);
            glitch = 1'b0;
            repeat (6) @(negedge clk);
            chk("R5 glitch", int'(locked), 0);
        end
        wait_idle();
        chk("R9 err", int'(lock_err), 1);
        chk("R9 busy", int'(busy), 0);
        chk("R9 rstn", int'(pll_rstn), 1);
        chk("R9 locked", int'(locked), 0);

        // R8: lock lost after trust, sticky until cleared
        model_delay = 8;
        request(0);
        wait_idle();
        chk("R10 err cleared", int'(lock_err), 0);
        chk("R8 locked first", int'(locked), 1);
        kill = 1'b1;
        repeat (2) @(negedge clk);
        kill = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 locked", int'(locked), 0);
        chk("R8 lost", int'(lock_lost), 1);
        chk("R8 busy", int'(busy), 0);
        repeat (20) @(negedge clk);
        chk("R8 sticky", int'(lock_lost), 1);
        chk("R8 still unlocked", int'(locked), 0);
        lost_clr = 1'b1;
        @(negedge clk);
        lost_clr = 1'b0;
        @(negedge clk);
        chk("R8 cleared", int'(lock_lost), 0);

        chk("R2 sel moves", sel_viol, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule